// File: doc/BRIEF.md
# Zero-overhead hardware loop controller

This controller works beside a 16-bit DSP sequencer and runs repeat loops without any branch instructions in the loop body. It watches every retired instruction. When the retired word is one of four loop opcodes, it records a loop frame: a restart address, a last-instruction address and an iteration count. Each frame is held in three stacks that are pushed and popped together. The count comes from an 8-bit immediate or from a register-file read port. A loop covers either the single following instruction or a block that ends, inclusively, at an address given in the opcode's second word.

On every retire the controller also compares the retired PC with the end address of the innermost frame. On a match it decrements that frame's count. If the count is still nonzero, it overrides the next PC with the frame's restart address in the same cycle. Otherwise it pops the frame, and execution falls through. A loop opcode with a zero count pushes nothing. A block loop with a zero count jumps past its last instruction, using the length of that instruction supplied by the sequencer. Frames nest up to the stack depth. A push beyond that depth is dropped and raises a sticky overflow flag.

The occupancy is held as a state machine with the states EMPTY (no frame), PARTIAL (some frames) and FULL (every entry used). The transitions are: push (EMPTY→PARTIAL, PARTIAL→PARTIAL or FULL), pop (FULL→PARTIAL, PARTIAL→PARTIAL or EMPTY), and replace (a pop and a push in the same cycle, which leaves the state as it is). A push in FULL without a pop is an overflow and also leaves the state as it is.

Top module: `hwloop_ctrl`

## Requirements
- R1: A retired word is decoded as follows. With `(w & 0xFFE0)==0x0040` it is a single-instruction loop counted by a register. With `(w & 0xFFE0)==0x0060` it is a block loop counted by a register. With `(w & 0xFF00)==0x1000` it is a single-instruction loop with an immediate count. With `(w & 0xFF00)==0x1100` it is a block loop with an immediate count. The immediate count is `w[7:0]`. For the register forms, `rf_sel` carries `w[4:0]` and the count is `rf_data`.
- R2: A loop opcode with a nonzero count pushes one frame. For the single forms, both the restart and end addresses are PC+1. For the block forms, the restart address is PC+2 and the end address is `ret_ext`.
- R3: A retire is a hit when a frame exists, its count is above zero and `ret_pc` equals its end address. A hit decrements that count by one, so a frame pushed with count N produces N-1 restarts.
- R4: On a hit whose decremented count is nonzero, `pc_ovr` is 1 and `pc_tgt` is the top restart address, in the same cycle.
- R5: On a hit whose decremented count is zero, all three stacks are popped at the next edge, and no restart override is produced. The enclosing frame becomes the top.
- R6: A loop opcode with a zero count pushes nothing and drives `pc_ovr`. The single forms target PC+1. The block forms target `ret_ext`+1 when `end_len_two`=0 and `ret_ext`+2 when it is 1.
- R7: A loop opcode with a nonzero count drives `pc_ovr` with the target PC+1 (single forms) or PC+2 (block forms).
- R8: Up to 4 frames nest. A push that finds all entries in use, after any same-cycle pop, is dropped. The stacks stay unchanged and `nest_ovf` is set and stays set until reset.
- R9: When a loop opcode retires at the end address of the top frame, the hit's decrement or pop and the new push both take effect. A restart override from the hit takes priority over the opcode's own target.
- R10: After reset, no frame exists and `nest_ovf` is 0.
- R11: With `ret_valid` low, or with a retired word that is not a loop opcode and not a hit, `pc_ovr` is 0 and the stacks do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 16 | Address of the retired instruction |
| ret_word | input | 16 | First word of the retired instruction |
| ret_ext | input | 16 | Second word of the retired instruction (end address of a block loop) |
| rf_sel | output | 5 | Register-file read select |
| rf_data | input | 16 | Register-file read data for `rf_sel` |
| end_len_two | input | 1 | The instruction at `ret_ext` is two words long |
| pc_ovr | output | 1 | Override the next PC this cycle |
| pc_tgt | output | 16 | Next PC when `pc_ovr` is 1 |
| nest_ovf | output | 1 | Sticky nesting overflow |

## Verification
The end-address check and the push of a new frame can occur in the same cycle. This happens when the last instruction of a loop body is itself a loop opcode. The bench provokes it directly: it retires loop opcodes whose PC equals the top end address, with counts that lead to both a restart and a pop. The random phase also steers about half of all retire addresses onto the current end address. The result is judged at the ports. The override must carry the restart address, and the later retires must show the new frame and the decremented or popped frame beneath it, as the bench's own stack model predicts.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RPT_REG = 3'd1,
        OP_BLK_REG = 3'd2,
        OP_RPT_IMM = 3'd3,
        OP_BLK_IMM = 3'd4
    } loop_op_t;

    localparam logic [15:0] MASK_REGFORM = 16'hFFE0;
    localparam logic [15:0] MASK_IMMFORM = 16'hFF00;
    localparam logic [15:0] CODE_RPT_REG = 16'h0040;
    localparam logic [15:0] CODE_BLK_REG = 16'h0060;
    localparam logic [15:0] CODE_RPT_IMM = 16'h1000;
    localparam logic [15:0] CODE_BLK_IMM = 16'h1100;

    function automatic loop_op_t classify_op(input logic [15:0] w);
        loop_op_t r;
        r = OP_NONE;
        if ((w & MASK_REGFORM) == CODE_RPT_REG)      r = OP_RPT_REG;
        else if ((w & MASK_REGFORM) == CODE_BLK_REG) r = OP_BLK_REG;
        else if ((w & MASK_IMMFORM) == CODE_RPT_IMM) r = OP_RPT_IMM;
        else if ((w & MASK_IMMFORM) == CODE_BLK_IMM) r = OP_BLK_IMM;
        return r;
    endfunction

endpackage

// File: rtl/hwloop_decode.sv
module hwloop_decode
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic [15:0]   ret_word,
    input  logic [AW-1:0] ret_ext,
    input  logic [CW-1:0] rf_data,
    input  logic          end_len_two,
    output logic [4:0]    rf_sel,
    output logic          op_ovr,
    output logic [AW-1:0] op_tgt,
    output logic          push_req,
    output logic [AW-1:0] push_start,
    output logic [AW-1:0] push_end,
    output logic [CW-1:0] push_cnt
);
    localparam int IMMW = 8;

    loop_op_t      op;
    logic          blk;
    logic          use_reg;
    logic [AW-1:0] after_one;
    logic [AW-1:0] after_two;
    logic [AW-1:0] skip_tgt;

    always_comb begin
        op = classify_op(ret_word);
        unique case (op)
            OP_RPT_REG: begin blk = 1'b0; use_reg = 1'b1; end
            OP_BLK_REG: begin blk = 1'b1; use_reg = 1'b1; end
            OP_RPT_IMM: begin blk = 1'b0; use_reg = 1'b0; end
            OP_BLK_IMM: begin blk = 1'b1; use_reg = 1'b0; end
            default:    begin blk = 1'b0; use_reg = 1'b0; end
        endcase
        rf_sel     = ret_word[4:0];
        push_cnt   = use_reg ? rf_data : CW'(ret_word[IMMW-1:0]);
        after_one  = ret_pc + AW'(1);
        after_two  = ret_pc + AW'(2);
        skip_tgt   = ret_ext + (end_len_two ? AW'(2) : AW'(1));
        push_start = blk ? after_two : after_one;
        push_end   = blk ? ret_ext : after_one;
        op_ovr     = ret_valid && (op != OP_NONE);
        push_req   = op_ovr && (push_cnt != '0);
        op_tgt     = (blk && (push_cnt == '0)) ? skip_tgt : push_start;
    end

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW-1:0] push_start,
    input  logic [AW-1:0] push_end,
    input  logic [CW-1:0] push_cnt,
    input  logic          hit,
    output logic [AW-1:0] top_start,
    output logic [AW-1:0] top_end,
    output logic [CW-1:0] top_cnt,
    output logic          has_frame,
    output logic          loop_back,
    output logic          nest_ovf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    logic [AW-1:0] start_q [DEPTH];
    logic [AW-1:0] end_q   [DEPTH];
    logic [CW-1:0] cnt_q   [DEPTH];

    occ_state_t    state_q, state_d;
    logic [PW-1:0] depth_q, depth_d, after_pop;
    logic          ovf_q, ovf_d;
    logic [IW-1:0] top_idx, push_idx;
    logic [CW-1:0] dec_cnt;
    logic          pop, do_push, is_full;

    // output decode of the occupancy state
    always_comb begin
        unique case (state_q)
            ST_EMPTY:   begin has_frame = 1'b0; is_full = 1'b0; end
            ST_PARTIAL: begin has_frame = 1'b1; is_full = 1'b0; end
            ST_FULL:    begin has_frame = 1'b1; is_full = 1'b1; end
            default:    begin has_frame = 1'b0; is_full = 1'b0; end
        endcase
    end

    always_comb begin
        top_idx   = IW'(depth_q - PW'(1));
        top_start = start_q[top_idx];
        top_end   = end_q[top_idx];
        top_cnt   = cnt_q[top_idx];
        dec_cnt   = top_cnt - CW'(1);
        pop       = hit && (dec_cnt == '0);
        loop_back = hit && !pop;
        after_pop = depth_q - PW'(pop);
        do_push   = push_req && (pop || !is_full);
        ovf_d     = ovf_q || (push_req && !pop && is_full);
        push_idx  = IW'(after_pop);
        depth_d   = after_pop + PW'(do_push);
        if (depth_d == '0)               state_d = ST_EMPTY;
        else if (depth_d == PW'(DEPTH))  state_d = ST_FULL;
        else                             state_d = ST_PARTIAL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            depth_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
            ovf_q   <= ovf_d;
        end
    end

    assign nest_ovf = ovf_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g] <= '0;
                end_q[g]   <= '0;
                cnt_q[g]   <= '0;
            end else begin
                if (loop_back && (top_idx == IW'(g)))
                    cnt_q[g] <= dec_cnt;
                if (do_push && (push_idx == IW'(g))) begin
                    start_q[g] <= push_start;
                    end_q[g]   <= push_end;
                    cnt_q[g]   <= push_cnt;
                end
            end
        end
    end

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= PW'(DEPTH));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !hit && state_q == ST_FULL) |=> ($stable(depth_q) && ovf_q));

    // R5
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_req) |=> (depth_q == $past(depth_q) - PW'(1)));

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !hit && state_q != ST_FULL)
        |=> (depth_q == $past(depth_q) + PW'(1) && top_cnt == $past(push_cnt)));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic [15:0]   ret_word,
    input  logic [AW-1:0] ret_ext,
    output logic [4:0]    rf_sel,
    input  logic [CW-1:0] rf_data,
    input  logic          end_len_two,
    output logic          pc_ovr,
    output logic [AW-1:0] pc_tgt,
    output logic          nest_ovf
);
    logic          op_ovr, push_req, hit, has_frame, loop_back;
    logic [AW-1:0] op_tgt, push_start, push_end, top_start, top_end;
    logic [CW-1:0] push_cnt, top_cnt;

    hwloop_decode #(.AW(AW), .CW(CW)) u_decode (
        .ret_valid   (ret_valid),
        .ret_pc      (ret_pc),
        .ret_word    (ret_word),
        .ret_ext     (ret_ext),
        .rf_data     (rf_data),
        .end_len_two (end_len_two),
        .rf_sel      (rf_sel),
        .op_ovr      (op_ovr),
        .op_tgt      (op_tgt),
        .push_req    (push_req),
        .push_start  (push_start),
        .push_end    (push_end),
        .push_cnt    (push_cnt)
    );

    hwloop_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_req),
        .push_start (push_start),
        .push_end   (push_end),
        .push_cnt   (push_cnt),
        .hit        (hit),
        .top_start  (top_start),
        .top_end    (top_end),
        .top_cnt    (top_cnt),
        .has_frame  (has_frame),
        .loop_back  (loop_back),
        .nest_ovf   (nest_ovf)
    );

    always_comb begin
        hit    = ret_valid && has_frame && (top_cnt != '0) && (ret_pc == top_end);
        pc_ovr = loop_back || op_ovr;
        pc_tgt = loop_back ? top_start : op_tgt;
    end

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |-> !pc_ovr);

    // R5
    last_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && top_cnt == CW'(1) && !op_ovr) |-> !pc_ovr);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && top_cnt > CW'(1)) |-> (pc_ovr && pc_tgt == top_start));

endmodule

// File: tb/test_hwloop_ctrl.sv
`timescale 1ns/1ps
module test_hwloop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [15:0] ret_pc = '0, ret_word = '0, ret_ext = '0, rf_data = '0;
    logic        end_len_two = 1'b0;
    logic [4:0]  rf_sel;
    logic        pc_ovr, nest_ovf;
    logic [15:0] pc_tgt;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_start [4];
    logic [15:0] m_end   [4];
    logic [15:0] m_cnt   [4];
    int          m_depth;
    bit          m_ovf;

    always #4 clk = ~clk;

    hwloop_ctrl i_hwloop_ctrl (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_word(ret_word), .ret_ext(ret_ext), .rf_sel(rf_sel),
        .rf_data(rf_data), .end_len_two(end_len_two), .pc_ovr(pc_ovr),
        .pc_tgt(pc_tgt), .nest_ovf(nest_ovf)
    );

    function automatic bit f_is_loop(input logic [15:0] w);
        return ((w & 16'hFFE0) == 16'h0040) || ((w & 16'hFFE0) == 16'h0060) ||
               ((w & 16'hFF00) == 16'h1000) || ((w & 16'hFF00) == 16'h1100);
    endfunction
    function automatic bit f_is_blk(input logic [15:0] w);
        return ((w & 16'hFFE0) == 16'h0060) || ((w & 16'hFF00) == 16'h1100);
    endfunction
    function automatic bit f_is_reg(input logic [15:0] w);
        return ((w & 16'hFFE0) == 16'h0040) || ((w & 16'hFFE0) == 16'h0060);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ret_valid = 1'b0;
        m_depth = 0; m_ovf = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pc_ovr == 1'b0, "R10 pc_ovr", 32'(pc_ovr), 0);
        chk(nest_ovf == 1'b0, "R10 nest_ovf", 32'(nest_ovf), 0);
    endtask

    task automatic step(input bit v, input logic [15:0] pc, input logic [15:0] w,
                        input logic [15:0] ext, input logic [15:0] rfd, input bit l2);
        bit          isl, blk, hit, lb, pp;
        logic [15:0] cnt, dec, e_tgt;
        bit          e_ovr;
        string       tag;
        int          top;
        @(negedge clk);
        ret_valid = v; ret_pc = pc; ret_word = w; ret_ext = ext;
        rf_data = rfd; end_len_two = l2;
        #1;
        isl = v && f_is_loop(w);
        blk = f_is_blk(w);
        cnt = f_is_reg(w) ? rfd : {8'h00, w[7:0]};
        top = m_depth - 1;
        hit = v && (m_depth > 0) && (m_cnt[top] != 0) && (pc == m_end[top]);
        dec = hit ? m_cnt[top] - 16'd1 : 16'd0;
        lb  = hit && (dec != 0);
        pp  = hit && (dec == 0);
        e_ovr = lb || isl;
        if (lb) e_tgt = m_start[top];
        else if (blk && cnt == 0) e_tgt = ext + (l2 ? 16'd2 : 16'd1);
        else e_tgt = pc + (blk ? 16'd2 : 16'd1);
        if (lb && isl)         tag = "R9 same-cycle";
        else if (lb)           tag = "R4 R2 restart";
        else if (pp)           tag = "R5 R3 last pass";
        else if (isl && cnt == 0) tag = "R6 zero count";
        else if (isl)          tag = "R7 loop entry";
        else                   tag = "R11 no effect";
        chk(pc_ovr == e_ovr, tag, 32'(pc_ovr), 32'(e_ovr));
        if (e_ovr) chk(pc_tgt == e_tgt, tag, 32'(pc_tgt), 32'(e_tgt));
        chk(nest_ovf == m_ovf, "R8 overflow flag", 32'(nest_ovf), 32'(m_ovf));
        if (v && f_is_reg(w)) chk(rf_sel == w[4:0], "R1 rf_sel", 32'(rf_sel), 32'(w[4:0]));
        @(posedge clk);
        if (lb) m_cnt[top] = dec;
        if (pp) m_depth--;
        if (isl && cnt != 0) begin
            if (m_depth < 4) begin
                m_start[m_depth] = pc + (blk ? 16'd2 : 16'd1);
                m_end[m_depth]   = blk ? ext : pc + 16'd1;
                m_cnt[m_depth]   = cnt;
                m_depth++;
            end else m_ovf = 1'b1;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();                                   // R10
        step(0, 16'h0050, 16'h1003, 16'h0, 16'h0, 0); // R11 idle
        step(1, 16'h0050, 16'h2345, 16'h0, 16'h0, 0); // R11 non-loop word
        // R7 R4 R5 R3: immediate single loop, count 3
        step(1, 16'h0100, 16'h1003, 16'h0, 16'h0, 0);
        step(1, 16'h0101, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0101, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0101, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0101, 16'h2000, 16'h0, 16'h0, 0);
        // R1 R2: register block loop, count 2 from register 5
        step(1, 16'h0200, 16'h0065, 16'h0210, 16'h0002, 0);
        step(0, 16'h0210, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0210, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0210, 16'h2000, 16'h0, 16'h0, 0);
        // R6: zero counts
        step(1, 16'h0300, 16'h1100, 16'h0320, 16'h0, 1);
        step(1, 16'h0300, 16'h1100, 16'h0320, 16'h0, 0);
        step(1, 16'h0330, 16'h0043, 16'h0, 16'h0000, 0);
        step(1, 16'h0331, 16'h2000, 16'h0, 16'h0, 0);
        // R8: five nested block loops
        for (int k = 0; k < 5; k++)
            step(1, 16'h0400 + 16'(k * 2), 16'h1102, 16'h0480 - 16'(k * 16), 16'h0, 0);
        step(1, 16'h0450, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0450, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0460, 16'h2000, 16'h0, 16'h0, 0);
        // R9: loop opcode retiring on the end address
        do_reset();
        step(1, 16'h0500, 16'h1102, 16'h0510, 16'h0, 0);
        step(1, 16'h0510, 16'h1005, 16'h0, 16'h0, 0);
        step(1, 16'h0511, 16'h2000, 16'h0, 16'h0, 0);
        step(1, 16'h0510, 16'h1101, 16'h0520, 16'h0, 0);
        step(1, 16'h0520, 16'h2000, 16'h0, 16'h0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] pc, w, ext, rfd;
            int kind;
            if (i % 250 == 0) do_reset();
            kind = $urandom_range(0, 5);
            pc   = 16'($urandom);
            if (m_depth > 0 && $urandom_range(0, 1) == 1) pc = m_end[m_depth - 1];
            rfd  = 16'($urandom_range(0, 3));
            case (kind)
                0: w = 16'h0040 | 16'($urandom_range(0, 31));
                1: w = 16'h0060 | 16'($urandom_range(0, 31));
                2: w = 16'h1000 | 16'($urandom_range(0, 3));
                3: w = 16'h1100 | 16'($urandom_range(0, 3));
                default: w = 16'h2000 | 16'($urandom_range(0, 4095));
            endcase
            ext = pc + 16'($urandom_range(1, 6));
            step($urandom_range(0, 7) != 0, pc, w, ext, rfd, 1'($urandom_range(0, 1)));
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule